// File: doc/BRIEF.md
# Shared-Function Digital I/O Port

This block is a four-line digital input port and a four-line digital output port that live at one host register offset. A host read at that offset returns the present state of the input lines. A host write at that offset loads a four-bit output latch. The input lines pass through a two-flop synchronizer. After that, the same lines feed other on-board functions: line 0 drives an external trigger, and line 2 drives an external clock. A host read still returns every line, whichever of these functions is in use.

When an expansion unit is connected and the host has set the expansion enable bit, the block enters expansion mode. In this mode the output pins stop showing the latch and carry the channel-select bits of the current scan-list entry. Input lines 1 and 3 then become the two external gain-select signals. The latch keeps its contents during expansion mode and still accepts writes, so the pins show the latched value again as soon as the mode ends.

Top module: `dio_share_port`

## Requirements
- R1: An input line change shows at the synchronized outputs after two rising clock edges. The read data, trigger, clock and gain outputs all take their line values from the synchronizer's last stage.
- R2: A read (`bus_rd`=1) at offset 3 returns the synchronized lines on `bus_rdata[3:0]`, with line k on bit k and all higher bits 0. In the same cycle, a read at any other offset, or no read, returns `bus_rdata`=0.
- R3: A write (`bus_wr`=1) at offset 3 loads `bus_wdata[3:0]` into the output latch at the clock edge. A write at any other offset leaves the latch unchanged.
- R4: `ext_trig` equals synchronized line 0 and `ext_clk` equals synchronized line 2 in every mode.
- R5: Expansion mode is `xp_present`=1 and `xp_enable`=1. In this mode `dout_pins` equals `scan_chsel` in the same cycle, `ext_gain[0]` is synchronized line 1 and `ext_gain[1]` is synchronized line 3.
- R6: Outside expansion mode, `ext_gain` is 0.
- R7: Outside expansion mode, `dout_pins` equals the latch. The latch keeps its value through expansion mode, and writes made during the mode still update it.
- R8: While `rst_n`=0, the latch and synchronizer are cleared, so `dout_pins`=0 outside expansion mode and a read at offset 3 returns 0.
- R9: A read at offset 3 returns all four synchronized lines in expansion mode as well, including the lines routed to gain, trigger and clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Host register offset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data |
| din_pins | input | 4 | Raw input lines |
| dout_pins | output | 4 | Output pins |
| xp_present | input | 1 | Expansion unit connected |
| xp_enable | input | 1 | Expansion enable control bit |
| scan_chsel | input | 4 | Channel-select bits of the current scan-list entry |
| ext_trig | output | 1 | External trigger, from line 0 |
| ext_clk | output | 1 | External clock, from line 2 |
| ext_gain | output | 2 | External gain-select, from lines 1 and 3 |

## Verification
There are two places where this block's functions can meet in the same cycle.

The first is a host write to the latch in the very cycle that expansion mode ends. The bench provokes this on purpose. On the next cycle the pins must show the newly written value and not the value that was latched before the write.

The second is a read of the port in a cycle where the input lines are toggling and gain routing is active. The bench judges this by comparing every output, on every clock, against a behavioural model that holds a two-deep history of the lines.

// File: rtl/dio_pkg.sv
package dio_pkg;
  localparam int PORT_W = 4;

  typedef enum logic {SRC_LATCH = 1'b0, SRC_SCAN = 1'b1} dout_src_e;

  // gain select is taken from the two odd lines, low line first
  function automatic logic [1:0] gain_pick(input logic [PORT_W-1:0] lines);
    return {lines[3], lines[1]};
  endfunction

  function automatic logic mode_on(input logic present, input logic enable);
    return present & enable;
  endfunction
endpackage

// File: rtl/dio_sync.sv
module dio_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else if (i == 0) stg[i] <= d;
        else stg[i] <= stg[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dio_out_latch.sv
module dio_out_latch #(
  parameter int W      = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] wdata,
  output logic [W-1:0]      q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= wdata[W-1:0];
  end
endmodule

// File: rtl/dio_route.sv
module dio_route
  import dio_pkg::*;
(
  input  logic [PORT_W-1:0] lines,
  input  logic [PORT_W-1:0] latch_q,
  input  logic [PORT_W-1:0] scan_chsel,
  input  logic              xp_mode,
  output logic [PORT_W-1:0] dout,
  output logic              trig,
  output logic              xclk,
  output logic [1:0]        gain,
  output dout_src_e         src
);
  always_comb begin
    src  = xp_mode ? SRC_SCAN : SRC_LATCH;
    dout = (src == SRC_SCAN) ? scan_chsel : latch_q;
    gain = xp_mode ? gain_pick(lines) : 2'b00;
    trig = lines[0];
    xclk = lines[2];
  end
endmodule

// File: rtl/dio_share_port.sv
module dio_share_port
  import dio_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int PORT_OFS    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [3:0]        din_pins,
  output logic [3:0]        dout_pins,
  input  logic              xp_present,
  input  logic              xp_enable,
  input  logic [3:0]        scan_chsel,
  output logic              ext_trig,
  output logic              ext_clk,
  output logic [1:0]        ext_gain
);
  localparam logic [ADDR_W-1:0] OFS = ADDR_W'(PORT_OFS);

  logic              port_sel;
  logic              wr_hit;
  logic              rd_hit;
  logic              xp_mode;
  logic [PORT_W-1:0] lines_s;
  logic [PORT_W-1:0] latch_q;
  dout_src_e         out_src;

  assign port_sel = (bus_addr == OFS);
  assign wr_hit   = bus_wr & port_sel;
  assign rd_hit   = bus_rd & port_sel;
  assign xp_mode  = mode_on(xp_present, xp_enable);

  dio_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(din_pins), .q(lines_s)
  );

  dio_out_latch #(.W(PORT_W), .DATA_W(DATA_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .load(wr_hit), .wdata(bus_wdata), .q(latch_q)
  );

  dio_route u_route (
    .lines(lines_s), .latch_q(latch_q), .scan_chsel(scan_chsel),
    .xp_mode(xp_mode), .dout(dout_pins), .trig(ext_trig), .xclk(ext_clk),
    .gain(ext_gain), .src(out_src)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_hit) bus_rdata[PORT_W-1:0] = lines_s;
  end
endmodule

// File: rtl/dio_share_port_chk.sv
module dio_share_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_hit,
  input logic              rd_hit,
  input logic              xp_mode,
  input logic [3:0]        latch_q,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [3:0]        din_pins,
  input logic [3:0]        dout_pins,
  input logic [3:0]        scan_chsel,
  input logic              ext_trig,
  input logic              ext_clk,
  input logic [1:0]        ext_gain
);
  logic [1:0] since_rst;
  logic       settled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end
  assign settled = (since_rst >= 2'd2);

  p_latch_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> latch_q == $past(bus_wdata[3:0]));
  p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(latch_q));
  p_pins_scan_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xp_mode |-> dout_pins == scan_chsel);
  p_pins_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !xp_mode |-> dout_pins == latch_q);
  p_gain_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !xp_mode |-> ext_gain == 2'b00);
  p_trig_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
    settled |-> (ext_trig == $past(din_pins[0], 2) && ext_clk == $past(din_pins[2], 2)));
  p_read_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && rd_hit) |-> bus_rdata[3:0] == $past(din_pins, 2));
  p_read_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |-> bus_rdata == '0);
  p_gain_lines_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && xp_mode) |-> ext_gain == {$past(din_pins[3], 2), $past(din_pins[1], 2)});
endmodule

bind dio_share_port dio_share_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .rd_hit(rd_hit), .xp_mode(xp_mode),
  .latch_q(latch_q), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .din_pins(din_pins), .dout_pins(dout_pins), .scan_chsel(scan_chsel),
  .ext_trig(ext_trig), .ext_clk(ext_clk), .ext_gain(ext_gain)
);

// File: tb/dio_share_port_tb.sv
module dio_share_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [3:0] din_pins = '0, dout_pins, scan_chsel = '0;
  logic       xp_present = 1'b0, xp_enable = 1'b0;
  logic       ext_trig, ext_clk;
  logic [1:0] ext_gain;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10ns clk = ~clk;

  dio_share_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .din_pins(din_pins),
    .dout_pins(dout_pins), .xp_present(xp_present), .xp_enable(xp_enable),
    .scan_chsel(scan_chsel), .ext_trig(ext_trig), .ext_clk(ext_clk), .ext_gain(ext_gain)
  );

  // reference model: line history queue and a shadow of the host-written value
  int hist[$] = '{0, 0};
  int shadow = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{0, 0};
      shadow = 0;
    end else begin
      hist.push_back(int'(din_pins));
      void'(hist.pop_front());
      if (bus_wr && bus_addr == 4'd3) shadow = bus_wdata % 16;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int  seen  = hist[0];
    bit  xp    = xp_present && xp_enable;
    int  bit1  = (seen / 2) % 2;
    int  bit3  = (seen / 8) % 2;
    int  e_rd  = (bus_rd && bus_addr == 4'd3) ? seen : 0;
    if (xp) begin
      check("R5 pins", int'(dout_pins), int'(scan_chsel));
      check("R5 gain", int'(ext_gain), bit3 * 2 + bit1);
      if (bus_rd && bus_addr == 4'd3) check("R9 read", int'(bus_rdata), e_rd);
    end else begin
      check("R7 pins", int'(dout_pins), shadow);
      check("R6 gain", int'(ext_gain), 0);
    end
    check("R2 read", int'(bus_rdata), e_rd);
    check("R4 trig", int'(ext_trig), seen % 2);
    check("R4 clk", int'(ext_clk), (seen / 4) % 2);
  endtask

  // check the present cycle at the falling edge, then change inputs
  task automatic step(input logic [3:0] a, input logic wr, input logic rd,
                      input logic [7:0] wd, input logic [3:0] di,
                      input logic xpp, input logic xpe, input logic [3:0] cs);
    @(negedge clk);
    compare_all();
    bus_addr = a; bus_wr = wr; bus_rd = rd; bus_wdata = wd;
    din_pins = di; xp_present = xpp; xp_enable = xpe; scan_chsel = cs;
  endtask

  initial begin
    #(20ns * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    // R8: reset state with lines and write data active
    din_pins = 4'hF; bus_addr = 4'd3; bus_rd = 1'b1; bus_wr = 1'b1; bus_wdata = 8'hA5;
    repeat (3) @(negedge clk);
    check("R8 pins", int'(dout_pins), 0);
    check("R8 read", int'(bus_rdata), 0);
    rst_n = 1'b1;
    step(4'd3, 0, 1, 8'h00, 4'h0, 0, 0, 4'h0);
    repeat (3) step(4'd3, 0, 1, 8'h00, 4'h0, 0, 0, 4'h0);
    // R1: a pulse on line 2 appears two edges later
    step(4'd3, 0, 1, 8'h00, 4'h4, 0, 0, 4'h0);
    step(4'd3, 0, 1, 8'h00, 4'h0, 0, 0, 4'h0);
    @(negedge clk); check("R1 early", int'(ext_clk), 1);
    step(4'd3, 0, 1, 8'h00, 4'h0, 0, 0, 4'h0);
    // R3: write at offset 3, then at other offsets
    step(4'd3, 1, 0, 8'hF6, 4'h9, 0, 0, 4'h0);
    step(4'd2, 1, 0, 8'h0F, 4'h9, 0, 0, 4'h0);
    step(4'd7, 1, 1, 8'h01, 4'h9, 0, 0, 4'h0);
    @(negedge clk); check("R3 other ofs", int'(dout_pins), 6);
    // R5/R7: expansion mode, write inside it
    step(4'd3, 0, 1, 8'h00, 4'hA, 1, 1, 4'hC);
    step(4'd3, 1, 1, 8'h03, 4'hA, 1, 1, 4'h5);
    step(4'd3, 0, 1, 8'h00, 4'hB, 1, 1, 4'h5);
    step(4'd3, 0, 1, 8'h00, 4'hB, 1, 0, 4'h5);
    @(negedge clk); check("R7 return", int'(dout_pins), 3);
    step(4'd3, 0, 1, 8'h00, 4'hB, 0, 1, 4'h5);
    // R7: write lands in the cycle expansion mode ends
    step(4'd3, 0, 0, 8'h00, 4'h2, 1, 1, 4'h7);
    step(4'd3, 1, 0, 8'h0E, 4'h2, 0, 0, 4'h7);
    step(4'd0, 0, 0, 8'h00, 4'h2, 0, 0, 4'h7);
    @(negedge clk); check("R7 same-cycle write", int'(dout_pins), 14);
    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      step((($urandom % 4) == 0) ? 4'($urandom) : 4'd3, 1'($urandom), 1'($urandom),
           8'($urandom), 4'($urandom), 1'($urandom), 1'($urandom), 4'($urandom));
    end
    // R8: reset again mid-run
    @(negedge clk); rst_n = 1'b0; xp_present = 1'b0; bus_rd = 1'b1; bus_addr = 4'd3;
    @(negedge clk);
    check("R8 re-reset pins", int'(dout_pins), 0);
    check("R8 re-reset read", int'(bus_rdata), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule